// File: doc/BRIEF.md
# Flash Self-Programming Access Guard

This block sits between the processor's self-programming request path and the flash controller. For every request it classifies two word addresses, the address of the instruction issuing the request and the flash address being targeted, into one of three regions: the general application area, a data-table region at the top of the application area, and the boot area above it. A request is allowed to proceed only when the issuing instruction runs from the boot area and the lock field of the targeted region permits the requested kind of access.

The verdict is registered. One cycle after a request is presented, the block raises either a grant or a one-cycle blocked pulse. Every refusal also sets a sticky violation flag. That flag stays high until a dedicated clear input drops it. The region boundaries are parameters given as word addresses. Three 2-bit lock fields come in as static inputs, one for each region.

Top module: `spm_guard`

## Requirements
- R1: While reset is high and in the first cycle after it is released, grant, blocked and violation are all low.
- R2: The verdict for a request presented in cycle N appears in cycle N+1. In a cycle after one with no request (req_valid low), both grant and blocked are low.
- R3: With the default parameters (table base 0xD000, boot base 0xE000), the regions are as follows. A word address of 0xE000 or above is boot. An address from 0xD000 to 0xDFFF is table. Any lower address is application. The same boundaries apply to the issuing address and to the target address.
- R4: A request whose issuing address lies in the application or table region is refused, whatever the lock fields hold.
- R5: A request from the boot region with req_write=1 (write or erase) is granted only when the target region's lock field is 2'b11. Lock values 2'b10, 2'b01 and 2'b00 refuse it.
- R6: A request from the boot region with req_write=0 (read) is granted when the target region's lock is 2'b11 or 2'b10. It is refused when the lock is 2'b00 or 2'b01.
- R7: Code in the boot region may target the boot region itself. Such a request is judged by lock_boot alone.
- R8: A target in the table region is judged by lock_table only, and a target in the application region by lock_app only. Neither field affects the other region.
- R9: grant and blocked are never high together. Each refused request produces a blocked pulse exactly one cycle long, aligned with its verdict cycle.
- R10: violation goes high in the same cycle as any blocked pulse and stays high until viol_clr is sampled high. If a refusal and viol_clr occur in the same cycle, the refusal wins and violation stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A self-programming request is presented this cycle |
| req_pc | input | ADDR_W | Word address of the issuing instruction |
| req_addr | input | ADDR_W | Target flash word address |
| req_write | input | 1 | 1 = write or erase, 0 = read |
| lock_app | input | 2 | Lock field of the application region |
| lock_table | input | 2 | Lock field of the table region |
| lock_boot | input | 2 | Lock field of the boot region |
| viol_clr | input | 1 | Clears the sticky violation flag |
| grant | output | 1 | Registered: the previous request may proceed |
| blocked | output | 1 | Registered one-cycle pulse: the previous request was refused |
| violation | output | 1 | Sticky refusal flag |

## Verification
The hardest case to reach is one where the two addresses and the lock fields each push the verdict a different way. For example, a boot-resident request targets the table region while the application lock is fully closed and the table lock is open, or the reverse. The stimulus places both addresses exactly on each region boundary (0xCFFF, 0xD000, 0xDFFF, 0xE000). For each placement it sets the three lock fields to disagree, so that a wrong region choice or a wrong lock selection flips the verdict. A separate sequence issues a refusal in the same cycle that viol_clr is high, which exercises the priority between setting and clearing the sticky flag.

// File: rtl/spm_guard_pkg.sv
package spm_guard_pkg;

    typedef enum logic [1:0] {
        RGN_APP   = 2'd0,
        RGN_TABLE = 2'd1,
        RGN_BOOT  = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        LK_FULL    = 2'b00,
        LK_RSVD    = 2'b01,
        LK_NOWRITE = 2'b10,
        LK_OPEN    = 2'b11
    } lock_e;

    typedef struct packed {
        logic grant;
        logic blocked;
    } verdict_t;

    // Lock policy: open allows all, no-write allows reads, the rest deny.
    function automatic logic lock_permits(input lock_e lk, input logic is_write);
        case (lk)
            LK_OPEN:    return 1'b1;
            LK_NOWRITE: return !is_write;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spm_region_decode.sv
module spm_region_decode
    import spm_guard_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] TABLE_START = 16'hD000,
    parameter logic [ADDR_W-1:0] BOOT_START  = 16'hE000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    always_comb begin
        if (addr >= BOOT_START)
            region = RGN_BOOT;
        else if (addr >= TABLE_START)
            region = RGN_TABLE;
        else
            region = RGN_APP;
    end

endmodule

// File: rtl/spm_lock_select.sv
module spm_lock_select
    import spm_guard_pkg::*;
(
    input  region_e    src_region,
    input  region_e    dst_region,
    input  logic       is_write,
    input  logic [1:0] lock_app,
    input  logic [1:0] lock_table,
    input  logic [1:0] lock_boot,
    output logic       allow
);

    lock_e dst_lock;

    always_comb begin
        case (dst_region)
            RGN_BOOT:  dst_lock = lock_e'(lock_boot);
            RGN_TABLE: dst_lock = lock_e'(lock_table);
            default:   dst_lock = lock_e'(lock_app);
        endcase
    end

    // Only boot-resident code may self-program; then the target lock rules.
    assign allow = (src_region == RGN_BOOT) && lock_permits(dst_lock, is_write);

endmodule

// File: rtl/spm_guard.sv
module spm_guard
    import spm_guard_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] TABLE_START = 16'hD000,
    parameter logic [ADDR_W-1:0] BOOT_START  = 16'hE000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        lock_app,
    input  logic [1:0]        lock_table,
    input  logic [1:0]        lock_boot,
    input  logic              viol_clr,
    output logic              grant,
    output logic              blocked,
    output logic              violation
);

    localparam int N_ADDR = 2;   // index 0: issuing address, 1: target

    logic [ADDR_W-1:0] addr_vec [N_ADDR];
    region_e           rgn_vec  [N_ADDR];
    logic              allow;
    verdict_t          verdict_d, verdict_q;
    logic              refuse_now;

    assign addr_vec[0] = req_pc;
    assign addr_vec[1] = req_addr;

    for (genvar i = 0; i < N_ADDR; i++) begin : g_dec
        spm_region_decode #(
            .ADDR_W      (ADDR_W),
            .TABLE_START (TABLE_START),
            .BOOT_START  (BOOT_START)
        ) u_dec (
            .addr   (addr_vec[i]),
            .region (rgn_vec[i])
        );
    end

    spm_lock_select u_lock (
        .src_region (rgn_vec[0]),
        .dst_region (rgn_vec[1]),
        .is_write   (req_write),
        .lock_app   (lock_app),
        .lock_table (lock_table),
        .lock_boot  (lock_boot),
        .allow      (allow)
    );

    assign refuse_now        = req_valid && !allow;
    assign verdict_d.grant   = req_valid && allow;
    assign verdict_d.blocked = refuse_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
            violation <= 1'b0;
        end else begin
            verdict_q <= verdict_d;
            violation <= (violation && !viol_clr) || refuse_now;
        end
    end

    assign grant   = verdict_q.grant;
    assign blocked = verdict_q.blocked;

    // R9
    mutex_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant && blocked));

    // R2
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !grant && !blocked);

    // R4
    boot_only_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && (req_pc < BOOT_START) |=> blocked);

    // R5
    write_lock_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && lock_app != 2'b11 && lock_table != 2'b11
            && lock_boot != 2'b11 |=> blocked);

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        violation && !viol_clr |=> violation);

    // R10
    rise_chk: assert property (@(posedge clk) disable iff (rst)
        blocked |-> violation);

endmodule

// File: tb/tb_spm_guard.sv
module tb_spm_guard;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_pc = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic [1:0]    lock_app = 2'b11;
    logic [1:0]    lock_table = 2'b11;
    logic [1:0]    lock_boot = 2'b11;
    logic          viol_clr = 1'b0;
    logic          grant, blocked, violation;

    spm_guard dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_pc(req_pc),
        .req_addr(req_addr), .req_write(req_write), .lock_app(lock_app),
        .lock_table(lock_table), .lock_boot(lock_boot), .viol_clr(viol_clr),
        .grant(grant), .blocked(blocked), .violation(violation)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    due;
        logic  g;
        logic  b;
        logic  v;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    logic model_viol = 1'b0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference policy from the requirements (R3, R5, R6, R7, R8)
    function automatic logic ref_allow(input logic [AW-1:0] pc, input logic [AW-1:0] a,
                                       input logic wr, input logic [1:0] la,
                                       input logic [1:0] lt, input logic [1:0] lb);
        logic [1:0] lk;
        if (pc < 16'hE000) return 1'b0;
        if (a >= 16'hE000)      lk = lb;
        else if (a >= 16'hD000) lk = lt;
        else                    lk = la;
        return (lk == 2'b11) || (lk == 2'b10 && !wr);
    endfunction

    task automatic apply(input logic v, input logic [AW-1:0] pc, input logic [AW-1:0] a,
                         input logic wr, input logic [1:0] la, input logic [1:0] lt,
                         input logic [1:0] lb, input logic clr, input string tag);
        exp_t e;
        logic ok;
        @(negedge clk);
        req_valid = v; req_pc = pc; req_addr = a; req_write = wr;
        lock_app = la; lock_table = lt; lock_boot = lb; viol_clr = clr;
        ok = ref_allow(pc, a, wr, la, lt, lb);
        e.due = cyc + 1;
        e.g = v && ok;
        e.b = v && !ok;
        model_viol = (model_viol && !clr) || e.b;
        e.v = model_viol;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input logic clr, input string tag);
        apply(1'b0, '0, '0, 1'b0, 2'b11, 2'b11, 2'b11, clr, tag);
    endtask

    // Monitor: compare each expected item in the cycle it falls due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (grant !== e.g || blocked !== e.b || violation !== e.v) begin
                n_bad++;
                $display("FAIL %s: got g/b/v=%b%b%b expected %b%b%b",
                         e.tag, grant, blocked, violation, e.g, e.b, e.v);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (grant !== 1'b0 || blocked !== 1'b0 || violation !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 in reset: got %b%b%b expected 000", grant, blocked, violation);
        end
        rst = 1'b0;
        @(negedge clk);
        n_vec++;
        if (grant !== 1'b0 || blocked !== 1'b0 || violation !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 after reset: got %b%b%b expected 000", grant, blocked, violation);
        end

        idle(1'b0, "R2 idle");
        apply(1, 16'hE100, 16'h0100, 1, 2'b11, 2'b11, 2'b11, 0, "R5 boot write open app");
        apply(1, 16'h0200, 16'h0100, 1, 2'b11, 2'b11, 2'b11, 0, "R4 app pc refused");
        idle(1'b0, "R10 sticky hold");
        idle(1'b0, "R9 blocked one cycle");
        idle(1'b1, "R10 clear");
        idle(1'b0, "R10 cleared stays low");
        apply(1, 16'hD010, 16'hE800, 0, 2'b11, 2'b11, 2'b11, 1, "R4 table pc refused, R10 set wins");
        apply(1, 16'hE000, 16'hD000, 1, 2'b11, 2'b10, 2'b11, 1, "R8 table lock 10 blocks write");
        apply(1, 16'hE000, 16'hD000, 1, 2'b00, 2'b11, 2'b00, 1, "R8 app lock ignored for table");
        apply(1, 16'hE000, 16'h1000, 1, 2'b00, 2'b11, 2'b11, 1, "R8 table lock ignored for app");
        apply(1, 16'hF000, 16'hD800, 0, 2'b00, 2'b10, 2'b00, 1, "R6 read under lock 10");
        apply(1, 16'hF000, 16'hD800, 0, 2'b11, 2'b00, 2'b11, 1, "R6 read under lock 00");
        apply(1, 16'hF000, 16'hD800, 0, 2'b11, 2'b01, 2'b11, 1, "R6 read under lock 01");
        apply(1, 16'hF000, 16'h0040, 1, 2'b10, 2'b11, 2'b11, 1, "R5 write under lock 10");
        apply(1, 16'hF000, 16'h0040, 1, 2'b01, 2'b11, 2'b11, 1, "R5 write under lock 01");
        apply(1, 16'hE000, 16'hCFFF, 1, 2'b00, 2'b11, 2'b11, 1, "R3 CFFF is app");
        apply(1, 16'hE000, 16'hDFFF, 1, 2'b00, 2'b11, 2'b00, 1, "R3 DFFF is table");
        apply(1, 16'hE000, 16'hE000, 1, 2'b11, 2'b11, 2'b00, 1, "R3 R7 E000 is boot");
        apply(1, 16'hFFFF, 16'hF000, 1, 2'b00, 2'b00, 2'b11, 1, "R7 boot writes boot");
        apply(1, 16'hFFFF, 16'hFFFF, 0, 2'b11, 2'b11, 2'b10, 1, "R7 boot reads boot lock 10");
        apply(1, 16'hDFFF, 16'h0000, 0, 2'b11, 2'b11, 2'b11, 1, "R3 R4 pc DFFF refused");
        apply(1, 16'hCFFF, 16'h0000, 0, 2'b11, 2'b11, 2'b11, 0, "R4 pc CFFF refused");
        apply(1, 16'hE000, 16'h0000, 0, 2'b11, 2'b11, 2'b11, 0, "R9 grant after block");
        idle(1'b1, "R10 clear again");
        idle(1'b0, "R2 idle final");
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule